// File: doc/BRIEF.md
# Flash Write Command Sequencer

This block accepts one write request at a time from a processor and runs a reduced flash programming handshake. It first presents the write command to the flash for one cycle. It then waits until the flash reports that programming is done, or until a programmable cycle limit runs out. The block reports its progress as a two-bit code, and a separate output shows whether the flash is free for direct access.

Three sticky event flags record an error (timeout), a finished write and an idle sequencer. Software can clear any flag by writing 0 to it. Writing 1 leaves a flag unchanged, and a read-modify-write read returns every flag as 1. This means that writing back an unchanged value never clears an event that arrived in the meantime. Each flag drives the interrupt line through its own enable. The idle flag can also raise a DMA request, which is held until it is acknowledged.

If software disables the sequencer while a write is in flight, the sequencer enters a draining state with its own code. It stays there until the flash finishes or a fixed bound of cycles has passed.

Top module: `flash_wseq`

## Requirements
- R1: `seq_code` reads 2'b00 when idle or disabled, 2'b01 while the command is presented, 2'b10 while waiting for the flash, and 2'b11 while draining after a disable. After reset it reads 2'b00, all flags are 0, `irq` and `dma_req` are 0, and `fl_free` is 1.
- R2: A request seen at a clock edge while enabled and idle gives code 01 in the following cycle, with `fl_cmd` high for exactly that cycle and `fl_addr`/`fl_data` equal to the request. Code 10 follows one cycle later.
- R3: Clearing `cfg_en` during code 01 or 10 gives code 11 and `fl_free` low. The block returns to 00 when `fl_done` is seen or after DRAIN_CYC (default 11) cycles in the draining state, whichever comes first. Draining sets no flag.
- R4: `fl_done` seen while waiting and enabled returns the block to code 00 and sets the finished flag (bit 1) and the idle flag (bit 0).
- R5: If `fl_done` is not seen during `tmo_limit` consecutive waiting cycles, the block returns to 00 and sets the error flag (bit 2) and the idle flag. The finished flag is not set.
- R6: A rising edge of `cfg_en` sets the idle flag.
- R7: A strobe on `flag_wr` clears each flag whose bit in `flag_wdata` is 0. The bit order is {error, finished, idle}. A bit written as 1 leaves its flag unchanged.
- R8: `flag_rd` returns 3'b111 while `rd_rmw` is high, and returns the flags otherwise.
- R9: `irq` is the OR of each flag ANDed with the bit at the same position in `cfg_irq_en`.
- R10: `dma_req` is the idle flag gated by `cfg_dma_en`. It stays high until `dma_ack`, and an acknowledge clears the idle and finished flags but not the error flag.
- R11: A request while the block is not idle, or while it is disabled, is ignored. The state, the flags and the latched address do not change.
- R12: When a hardware set and a software clear of one flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Sequencer enable |
| cfg_irq_en | input | 3 | Interrupt enables {error, finished, idle} |
| cfg_dma_en | input | 1 | DMA request enable for the idle flag |
| tmo_limit | input | TW | Timeout limit in waiting cycles |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 3 | Flag write value; a 0 clears the flag |
| rd_rmw | input | 1 | Current flag read is part of a read-modify-write |
| flag_rd | output | 3 | Flag read value |
| seq_code | output | 2 | Sequencer state code |
| fl_free | output | 1 | No flash sequence in flight; direct access allowed |
| fl_cmd | output | 1 | Write command strobe to flash |
| fl_addr | output | AW | Flash address |
| fl_data | output | DW | Flash data |
| fl_done | input | 1 | Flash program done |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA transfer done |

## Verification
The critical coincidence is a hardware flag set and a software clear of the same flag in one cycle. The bench provokes it by asserting `fl_done` on a waiting cycle together with a `flag_wr` strobe of all zeros. It then expects the finished and idle flags to be 1 and the error flag to be 0. The DMA acknowledge is a second clearing path, so the bench also checks that it removes the idle and finished flags and keeps the error flag.

// File: rtl/fws_pkg.sv
package fws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_SUBMIT = 2'b01,
      ST_WAIT   = 2'b10,
      ST_DRAIN  = 2'b11
   } fws_state_e;

   localparam int F_IDL = 0;
   localparam int F_FIN = 1;
   localparam int F_ERR = 2;
   localparam int NFLAG = 3;
endpackage

// File: rtl/fws_ctrl.sv
module fws_ctrl
   import fws_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int TW        = 8,
   parameter int DRAIN_CYC = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic [TW-1:0] tmo_limit,
   input  logic          fl_done,
   output fws_state_e    state,
   output logic          fl_cmd,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_data,
   output logic          ev_fin,
   output logic          ev_err,
   output logic          ev_idl
);
   localparam int DCW = $clog2(DRAIN_CYC + 1);
   localparam logic [DCW-1:0] DLAST = DCW'(DRAIN_CYC - 1);

   fws_state_e     nxt;
   logic [TW-1:0]  tcnt;
   logic [DCW-1:0] dcnt;
   logic           en_q;
   logic           tmo_hit;

   assign tmo_hit = ({1'b0, tcnt} + {{TW{1'b0}}, 1'b1}) >= {1'b0, tmo_limit};

   always_comb begin
      nxt    = state;
      ev_fin = 1'b0;
      ev_err = 1'b0;
      unique case (state)
         ST_IDLE:   if (en && req_valid) nxt = ST_SUBMIT;
         ST_SUBMIT: nxt = en ? ST_WAIT : ST_DRAIN;
         ST_WAIT: begin
            if (!en) begin
               nxt = ST_DRAIN;
            end else if (fl_done) begin
               nxt    = ST_IDLE;
               ev_fin = 1'b1;
            end else if (tmo_hit) begin
               nxt    = ST_IDLE;
               ev_err = 1'b1;
            end
         end
         ST_DRAIN:  if (fl_done || dcnt == DLAST) nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   assign ev_idl = ev_fin | ev_err | (en & ~en_q);
   assign fl_cmd = (state == ST_SUBMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         tcnt    <= '0;
         dcnt    <= '0;
         en_q    <= 1'b0;
         fl_addr <= '0;
         fl_data <= '0;
      end else begin
         state <= nxt;
         en_q  <= en;
         tcnt  <= (state == ST_WAIT && nxt == ST_WAIT) ? tcnt + 1'b1 : '0;
         dcnt  <= (state == ST_DRAIN && nxt == ST_DRAIN) ? dcnt + 1'b1 : '0;
         if (state == ST_IDLE && nxt == ST_SUBMIT) begin
            fl_addr <= req_addr;
            fl_data <= req_data;
         end
      end
   end

   a_r2_submit_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUBMIT && en) |=> (state == ST_WAIT));
   a_r3_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN && dcnt == DLAST) |=> (state == ST_IDLE));
   a_r4_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && en && fl_done) |=> (state == ST_IDLE));
   a_r11_busy_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(fl_addr));
endmodule

// File: rtl/fws_flags.sv
module fws_flags #(
   parameter int NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic          sw_wr,
   input  logic [NF-1:0] sw_wdata,
   input  logic [NF-1:0] hw_clr,
   output logic [NF-1:0] flags
);
   for (genvar i = 0; i < NF; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        flags[i] <= 1'b0;
         else if (set[i])                   flags[i] <= 1'b1;
         else if (hw_clr[i])                flags[i] <= 1'b0;
         else if (sw_wr && !sw_wdata[i])    flags[i] <= 1'b0;
      end

      a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);
      a_r7_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && sw_wr && sw_wdata[i] && !hw_clr[i]) |=> flags[i]);
   end
endmodule

// File: rtl/flash_wseq.sv
module flash_wseq
   import fws_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int TW        = 8,
   parameter int DRAIN_CYC = 11,
   parameter bit REG_IRQ   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic [NFLAG-1:0] cfg_irq_en,
   input  logic             cfg_dma_en,
   input  logic [TW-1:0]    tmo_limit,
   input  logic             req_valid,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_data,
   input  logic             flag_wr,
   input  logic [NFLAG-1:0] flag_wdata,
   input  logic             rd_rmw,
   output logic [NFLAG-1:0] flag_rd,
   output logic [1:0]       seq_code,
   output logic             fl_free,
   output logic             fl_cmd,
   output logic [AW-1:0]    fl_addr,
   output logic [DW-1:0]    fl_data,
   input  logic             fl_done,
   output logic             irq,
   output logic             dma_req,
   input  logic             dma_ack
);
   if (DRAIN_CYC < 1) begin : g_bad_drain
      $error("DRAIN_CYC must be at least 1");
   end
   if (TW < 1 || AW < 1 || DW < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   fws_state_e       state;
   logic             ev_fin, ev_err, ev_idl;
   logic [NFLAG-1:0] set_v, clr_v, flags;

   fws_ctrl #(.AW(AW), .DW(DW), .TW(TW), .DRAIN_CYC(DRAIN_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(cfg_en),
      .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
      .tmo_limit(tmo_limit), .fl_done(fl_done),
      .state(state), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_data(fl_data),
      .ev_fin(ev_fin), .ev_err(ev_err), .ev_idl(ev_idl)
   );

   always_comb begin
      set_v        = '0;
      set_v[F_IDL] = ev_idl;
      set_v[F_FIN] = ev_fin;
      set_v[F_ERR] = ev_err;
      clr_v        = '0;
      clr_v[F_IDL] = dma_ack & dma_req;
      clr_v[F_FIN] = dma_ack & dma_req;
   end

   fws_flags #(.NF(NFLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(set_v),
      .sw_wr(flag_wr), .sw_wdata(flag_wdata), .hw_clr(clr_v), .flags(flags)
   );

   assign flag_rd  = rd_rmw ? {NFLAG{1'b1}} : flags;
   assign seq_code = state;
   assign fl_free  = (state == ST_IDLE);
   assign dma_req  = flags[F_IDL] & cfg_dma_en;

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |(flags & cfg_irq_en);
      end
   end else begin : g_irq_comb
      assign irq = |(flags & cfg_irq_en);
      a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (|flags));
   end

   a_r10_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && !dma_ack && !(flag_wr && !flag_wdata[F_IDL])) |=> (dma_req || !cfg_dma_en));
   a_r3_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_WAIT && !$past(cfg_en)) |-> !fl_free);
endmodule

// File: tb/tb_flash_wseq.sv
module tb_flash_wseq;
   localparam int AW = 16, DW = 16, TW = 8;
   localparam logic [3:0] IRQ_TBL [8] = '{4'b0000, 4'b0011, 4'b0100, 4'b0111,
                                          4'b1001, 4'b1011, 4'b1101, 4'b1111};

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_en = 0, cfg_dma_en = 0, req_valid = 0, flag_wr = 0, rd_rmw = 0;
   logic fl_done = 0, dma_ack = 0;
   logic [2:0] cfg_irq_en = 0, flag_wdata = 0, flag_rd;
   logic [TW-1:0] tmo_limit = 8'd3;
   logic [AW-1:0] req_addr = 0, fl_addr;
   logic [DW-1:0] req_data = 0, fl_data;
   logic [1:0] seq_code;
   logic fl_free, fl_cmd, irq, dma_req;
   int total = 0, bad = 0;

   always #4 clk = ~clk;

   flash_wseq dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
      .cfg_dma_en(cfg_dma_en), .tmo_limit(tmo_limit), .req_valid(req_valid),
      .req_addr(req_addr), .req_data(req_data), .flag_wr(flag_wr),
      .flag_wdata(flag_wdata), .rd_rmw(rd_rmw), .flag_rd(flag_rd),
      .seq_code(seq_code), .fl_free(fl_free), .fl_cmd(fl_cmd),
      .fl_addr(fl_addr), .fl_data(fl_data), .fl_done(fl_done), .irq(irq),
      .dma_req(dma_req), .dma_ack(dma_ack)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr_flags(logic [2:0] v);
      flag_wr = 1; flag_wdata = v;
      step();
      flag_wr = 0; flag_wdata = 0;
   endtask

   task automatic start_req(logic [15:0] a, logic [15:0] d);
      req_valid = 1; req_addr = a; req_data = d;
      step();
      req_valid = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(2);
      rst_n = 1;
      #1;
      chk("R1 reset code", seq_code, 0);
      chk("R1 reset flags", flag_rd, 0);
      chk("R1 reset irq/dma", {irq, dma_req}, 0);
      chk("R1 reset free", fl_free, 1);

      cfg_en = 1;
      step();
      chk("R6 enable sets idle", flag_rd, 3'b001);
      wr_flags(3'b110);
      chk("R7 write 0 clears idle", flag_rd, 3'b000);

      start_req(16'hA55A, 16'h1234);
      chk("R2 submit code", seq_code, 2'b01);
      chk("R2 cmd strobe", fl_cmd, 1);
      chk("R2 addr/data", {fl_addr, fl_data}, {16'hA55A, 16'h1234});
      step();
      chk("R2 wait code", seq_code, 2'b10);
      chk("R2 single strobe", fl_cmd, 0);
      req_valid = 1; req_addr = 16'hBEEF;
      step();
      req_valid = 0;
      chk("R11 busy request ignored", seq_code, 2'b10);
      fl_done = 1;
      step();
      fl_done = 0;
      chk("R4 done code", seq_code, 2'b00);
      chk("R4 done flags", flag_rd, 3'b011);
      chk("R11 addr kept", fl_addr, 16'hA55A);

      wr_flags(3'b000);
      start_req(16'h0010, 16'h0020);
      step(3);
      chk("R5 still waiting", seq_code, 2'b10);
      step();
      chk("R5 timeout code", seq_code, 2'b00);
      chk("R5 timeout flags", flag_rd, 3'b101);

      wr_flags(3'b111);
      chk("R7 write 1 keeps", flag_rd, 3'b101);
      rd_rmw = 1; #1;
      chk("R8 rmw read", flag_rd, 3'b111);
      rd_rmw = 0; #1;
      chk("R8 normal read", flag_rd, 3'b101);

      for (int i = 0; i < 8; i++) begin
         cfg_irq_en = IRQ_TBL[i][3:1];
         #1;
         chk("R9 irq gating", irq, IRQ_TBL[i][0]);
      end
      cfg_irq_en = 0;

      start_req(16'h0030, 16'h0040);
      step();
      fl_done = 1; step(); fl_done = 0;
      chk("R4 flags full", flag_rd, 3'b111);
      cfg_dma_en = 1; #1;
      chk("R10 dma req", dma_req, 1);
      step(2);
      chk("R10 dma held", dma_req, 1);
      dma_ack = 1; step(); dma_ack = 0;
      chk("R10 ack clears idle/fin", flag_rd, 3'b100);
      chk("R10 req drops", dma_req, 0);

      start_req(16'h0050, 16'h0060);
      step();
      fl_done = 1; flag_wr = 1; flag_wdata = 3'b000;
      step();
      fl_done = 0; flag_wr = 0;
      chk("R12 set wins over clear", flag_rd, 3'b011);

      cfg_dma_en = 0;
      wr_flags(3'b000);
      start_req(16'h0070, 16'h0080);
      step();
      cfg_en = 0;
      step();
      chk("R3 drain code", seq_code, 2'b11);
      chk("R3 drain blocks", fl_free, 0);
      step(10);
      chk("R3 drain before bound", seq_code, 2'b11);
      step();
      chk("R3 drain ends", seq_code, 2'b00);
      chk("R3 drain free", fl_free, 1);
      chk("R3 no flags", flag_rd, 3'b000);

      cfg_en = 1; step();
      chk("R6 re-enable idle", flag_rd, 3'b001);
      start_req(16'h0090, 16'h00A0);
      cfg_en = 0; step();
      chk("R3 drain from submit", seq_code, 2'b11);
      fl_done = 1; step(); fl_done = 0;
      chk("R3 early drain end", seq_code, 2'b00);
      chk("R3 flags unchanged", flag_rd, 3'b001);

      req_valid = 1; step(); req_valid = 0;
      chk("R11 disabled ignored", {seq_code, fl_cmd}, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule